// File: doc/BRIEF.md
# Two-Bank Endpoint Buffer with Error Flags

This block is the storage of one device-side USB endpoint. It has two equal banks that are used in ping-pong order. It sits between a packet engine and a CPU register interface. When the endpoint receives (OUT), the packet engine streams bytes into the next free bank, and the CPU reads the bank out and then releases it. When the endpoint transmits (IN), the CPU fills a bank and commits it, and the packet engine drains committed banks in the order the CPU committed them.

The block defines what happens when things go wrong:

- **Oversized packet.** A packet longer than a bank is cut to the bank size but is still accepted, and the overflow flag is raised.
- **Failed CRC.** A packet that fails its CRC raises the CRC error flag, and it still raises receive-complete.
- **No bank available.** In isochronous mode, a packet that finds no usable bank raises the underflow flag.
- **Kill command.** The CPU can discard the bank it committed most recently, before that bank is transmitted.

All flags stay set until the CPU clears them. Each flag is gated by its own enable bit onto a single interrupt line.

Top module: `usb_ep_bank_mgr`

## Requirements
- R1: In OUT mode (`epIsIn`=0), a packet of n ≤ BANK_BYTES bytes fills the next bank. At the same time it sets flag bit 0 (receive-complete) and raises `bankReady`. Then `cpuByteCount` reads n, and successive `cpuRdEn` pulses present the bytes on `cpuRdData` in arrival order.
- R2: Banks are used in ping-pong order. Two packets received back to back are read by the CPU in arrival order, and `cpuRelease` hands the CPU the next bank.
- R3: An OUT packet longer than BANK_BYTES keeps only its first BANK_BYTES bytes and sets `cpuByteCount` to BANK_BYTES. It sets flag bit 2 (overflow) together with flag bit 0.
- R4: An OUT packet that ends with `pktCrcOk`=0 sets flag bit 3 (CRC error) and also flag bit 0. Its bytes remain readable.
- R5: An OUT packet that starts while both banks are full is dropped, and the stored data is unchanged. In isochronous mode (`isoMode`=1) this sets flag bit 1 (underflow). Otherwise no flag is set.
- R6: In IN mode, an `inReq` that finds no committed bank sets flag bit 1 in isochronous mode, and sets no flag otherwise.
- R7: A `cpuRdEn` pulse while no OUT bank is ready has no effect. It sets no flag, and the next packet is read from its first byte.
- R8: In IN mode, CPU-written bytes become a committed bank on `cpuRelease`. `inReady` and `inLen` describe the oldest committed bank. After `inReq`, `inRdEn` steps through its bytes on `inData`, and `inDone` frees it.
- R9: `cpuKill` discards the most recently committed IN bank. That bank is never drained, and it becomes the CPU's bank again with a count of 0. A kill aimed at the bank currently being drained is ignored.
- R10: In IN mode, OUT packet strobes, including a zero-length packet, change no flag and no bank state.
- R11: Each flag stays set until a 1 is written to its bit of `clrFlags`. Clearing one bit leaves the other bits unchanged.
- R12: `irq` is high exactly when some flag bit is set whose `intEn` bit is also set.
- R13: After reset, all flags are 0, no bank is full, `bankReady` is 0 in OUT mode, and `inReady` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| isoMode | input | 1 | Endpoint is isochronous |
| epIsIn | input | 1 | Endpoint direction: 1 = IN (transmit), 0 = OUT (receive) |
| pktStart | input | 1 | OUT packet begins |
| pktValid | input | 1 | OUT data byte valid |
| pktData | input | DATA_W | OUT data byte |
| pktEnd | input | 1 | OUT packet ends (never in the same cycle as a byte) |
| pktCrcOk | input | 1 | CRC result, sampled with pktEnd |
| inReq | input | 1 | Host requests an IN packet |
| inRdEn | input | 1 | Advance the IN drain pointer |
| inDone | input | 1 | IN packet fully sent; free its bank |
| inData | output | DATA_W | Current IN byte |
| inLen | output | CW | Byte count of the oldest committed IN bank |
| inReady | output | 1 | A committed IN bank is waiting |
| cpuWrEn | input | 1 | CPU byte write (IN mode) |
| cpuWrData | input | DATA_W | CPU write byte |
| cpuRdEn | input | 1 | CPU byte read advance (OUT mode) |
| cpuRdData | output | DATA_W | CPU read byte |
| cpuRelease | input | 1 | Release (OUT) or commit (IN) the CPU's bank |
| cpuKill | input | 1 | Discard the most recently committed IN bank |
| bankReady | output | 1 | The CPU may access its bank |
| cpuByteCount | output | CW | Byte count of the CPU's bank |
| clrFlags | input | 4 | Per-flag clear strobes |
| intEn | input | 4 | Per-flag interrupt enables |
| flags | output | 4 | Sticky flags: 0 rx-complete, 1 underflow, 2 overflow, 3 CRC error |
| irq | output | 1 | Interrupt request |

## Verification
Two situations are hard to reach from the ports:

- **A dropped OUT packet.** Both banks must be full while the CPU still holds unread data, so the bench receives two packets without releasing either one. It then sends a third packet once in non-isochronous mode and once in isochronous mode, and afterwards confirms that the first two packets come back intact and in order.
- **A kill that must be refused.** The bench commits two IN banks, kills the newer one, and starts draining the older one. It then issues a second kill and checks that `inReady` and `inLen` do not move.

Packet lengths from zero up to past the bank size are swept, and the stored count, the overflow flag and the read-back bytes are all computed arithmetically.

// File: rtl/usb_ep_bank_pkg.sv
package usb_ep_bank_pkg;
  localparam int NUM_FLAGS  = 4;
  localparam int FLAG_RX    = 0;
  localparam int FLAG_UNDER = 1;
  localparam int FLAG_OVER  = 2;
  localparam int FLAG_CRC   = 3;

  // Strobes from control to the datapath
  typedef struct packed {
    logic       pktWr;     // store packet byte in pktBank
    logic       cpuWr;     // store CPU byte in cpuBank
    logic       pktRd;     // advance drain index
    logic       pktRdRst;  // restart drain index
    logic       cpuRd;     // advance CPU read index
    logic       cpuRdRst;  // restart CPU read index
    logic [1:0] clrCnt;    // per-bank count clear
    logic       pktBank;
    logic       cpuBank;
  } bankCtl_t;
endpackage

// File: rtl/usb_ep_bank_data.sv
module usb_ep_bank_data
  import usb_ep_bank_pkg::*;
#(
  parameter int BANK_BYTES = 8,
  parameter int DATA_W     = 8,
  localparam int CW = $clog2(BANK_BYTES + 1),
  localparam int IW = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bankCtl_t             ctl,
  input  logic [DATA_W-1:0]    pktData,
  input  logic [DATA_W-1:0]    cpuWrData,
  output logic [1:0][CW-1:0]   cnt,
  output logic [1:0]           cntSat,
  output logic [DATA_W-1:0]    inData,
  output logic [DATA_W-1:0]    cpuRdData
);
  localparam logic [IW-1:0] LAST_IDX = IW'(BANK_BYTES - 1);

  logic [DATA_W-1:0] mem [2][BANK_BYTES];
  logic [IW-1:0] drainIdx, cpuIdx;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic wrHere;
    assign cntSat[b] = (cnt[b] == CW'(BANK_BYTES));
    assign wrHere = (ctl.pktWr && ctl.pktBank == 1'(b)) ||
                    (ctl.cpuWr && ctl.cpuBank == 1'(b));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        cnt[b] <= '0;
      else if (ctl.clrCnt[b])           cnt[b] <= '0;
      else if (wrHere && !cntSat[b])    cnt[b] <= cnt[b] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.pktWr && !cntSat[ctl.pktBank])
      mem[ctl.pktBank][cnt[ctl.pktBank][IW-1:0]] <= pktData;
    if (ctl.cpuWr && !cntSat[ctl.cpuBank])
      mem[ctl.cpuBank][cnt[ctl.cpuBank][IW-1:0]] <= cpuWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drainIdx <= '0;
      cpuIdx   <= '0;
    end else begin
      if (ctl.pktRdRst)                         drainIdx <= '0;
      else if (ctl.pktRd && drainIdx != LAST_IDX) drainIdx <= drainIdx + 1'b1;
      if (ctl.cpuRdRst)                         cpuIdx <= '0;
      else if (ctl.cpuRd && cpuIdx != LAST_IDX)   cpuIdx <= cpuIdx + 1'b1;
    end
  end

  assign inData    = mem[ctl.pktBank][drainIdx];
  assign cpuRdData = mem[ctl.cpuBank][cpuIdx];
endmodule

// File: rtl/usb_ep_bank_ctrl.sv
module usb_ep_bank_ctrl
  import usb_ep_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 isoMode,
  input  logic                 epIsIn,
  input  logic                 pktStart,
  input  logic                 pktValid,
  input  logic                 pktEnd,
  input  logic                 pktCrcOk,
  input  logic                 inReq,
  input  logic                 inRdEn,
  input  logic                 inDone,
  input  logic                 cpuWrEn,
  input  logic                 cpuRdEn,
  input  logic                 cpuRelease,
  input  logic                 cpuKill,
  input  logic [NUM_FLAGS-1:0] clrFlags,
  input  logic [1:0]           cntSat,
  output bankCtl_t             ctl,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 bankReady,
  output logic                 inReady
);
  logic [1:0] full, fullSet, fullClr;
  logic pktPtr, cpuPtr, rxActive, ovfPend, draining;
  logic startOk, startDrop, byteAcc, endAcc, cpuRdOk, outRelease;
  logic inWr, inCommit, inKill, killBank, reqHit, reqMiss, drainRd, drainEnd;
  logic [NUM_FLAGS-1:0] flagSet;

  always_comb begin
    startOk    = !epIsIn && pktStart && !full[pktPtr];
    startDrop  = !epIsIn && pktStart && full[pktPtr];
    byteAcc    = !epIsIn && rxActive && pktValid;
    endAcc     = !epIsIn && rxActive && pktEnd;
    cpuRdOk    = !epIsIn && cpuRdEn && full[cpuPtr];
    outRelease = !epIsIn && cpuRelease && full[cpuPtr];
    inWr       = epIsIn && cpuWrEn && !full[cpuPtr];
    inCommit   = epIsIn && cpuRelease && !full[cpuPtr];
    killBank   = ~cpuPtr;
    inKill     = epIsIn && cpuKill && !cpuRelease && full[killBank] &&
                 !(draining && pktPtr == killBank);
    reqHit     = epIsIn && inReq && !draining && full[pktPtr];
    reqMiss    = epIsIn && inReq && !draining && !full[pktPtr];
    drainRd    = epIsIn && draining && inRdEn;
    drainEnd   = epIsIn && draining && inDone;

    ctl          = '0;
    ctl.pktWr    = byteAcc;
    ctl.cpuWr    = inWr;
    ctl.pktRd    = drainRd;
    ctl.pktRdRst = reqHit;
    ctl.cpuRd    = cpuRdOk;
    ctl.cpuRdRst = outRelease;
    ctl.pktBank  = pktPtr;
    ctl.cpuBank  = cpuPtr;
    if (startOk || drainEnd) ctl.clrCnt[pktPtr]   = 1'b1;
    if (outRelease)          ctl.clrCnt[cpuPtr]   = 1'b1;
    if (inKill)              ctl.clrCnt[killBank] = 1'b1;

    fullSet = '0;
    fullClr = '0;
    if (endAcc)                 fullSet[pktPtr]   = 1'b1;
    if (inCommit)               fullSet[cpuPtr]   = 1'b1;
    if (outRelease)             fullClr[cpuPtr]   = 1'b1;
    if (drainEnd)               fullClr[pktPtr]   = 1'b1;
    if (inKill)                 fullClr[killBank] = 1'b1;

    flagSet             = '0;
    flagSet[FLAG_RX]    = endAcc;
    flagSet[FLAG_UNDER] = isoMode && (startDrop || reqMiss);
    flagSet[FLAG_OVER]  = endAcc && ovfPend;
    flagSet[FLAG_CRC]   = endAcc && !pktCrcOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      full     <= '0;
      pktPtr   <= 1'b0;
      cpuPtr   <= 1'b0;
      rxActive <= 1'b0;
      ovfPend  <= 1'b0;
      draining <= 1'b0;
      flags    <= '0;
    end else begin
      full  <= (full & ~fullClr) | fullSet;
      flags <= (flags & ~clrFlags) | flagSet;
      if (endAcc || drainEnd)                pktPtr <= ~pktPtr;
      if (outRelease || inCommit || inKill)  cpuPtr <= ~cpuPtr;
      if (startOk)       rxActive <= 1'b1;
      else if (endAcc)   rxActive <= 1'b0;
      if (startOk)                        ovfPend <= 1'b0;
      else if (byteAcc && cntSat[pktPtr]) ovfPend <= 1'b1;
      if (reqHit)        draining <= 1'b1;
      else if (drainEnd) draining <= 1'b0;
    end
  end

  assign bankReady = epIsIn ? !full[cpuPtr] : full[cpuPtr];
  assign inReady   = epIsIn && full[pktPtr];
endmodule

// File: rtl/usb_ep_bank_mgr.sv
module usb_ep_bank_mgr
  import usb_ep_bank_pkg::*;
#(
  parameter int BANK_BYTES = 8,
  parameter int DATA_W     = 8,
  localparam int CW = $clog2(BANK_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 isoMode,
  input  logic                 epIsIn,
  input  logic                 pktStart,
  input  logic                 pktValid,
  input  logic [DATA_W-1:0]    pktData,
  input  logic                 pktEnd,
  input  logic                 pktCrcOk,
  input  logic                 inReq,
  input  logic                 inRdEn,
  input  logic                 inDone,
  output logic [DATA_W-1:0]    inData,
  output logic [CW-1:0]        inLen,
  output logic                 inReady,
  input  logic                 cpuWrEn,
  input  logic [DATA_W-1:0]    cpuWrData,
  input  logic                 cpuRdEn,
  output logic [DATA_W-1:0]    cpuRdData,
  input  logic                 cpuRelease,
  input  logic                 cpuKill,
  output logic                 bankReady,
  output logic [CW-1:0]        cpuByteCount,
  input  logic [NUM_FLAGS-1:0] clrFlags,
  input  logic [NUM_FLAGS-1:0] intEn,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq
);
  bankCtl_t          ctl;
  logic [1:0][CW-1:0] cnt;
  logic [1:0]        cntSat;

  usb_ep_bank_ctrl u_ctrl (
    .clk, .rstN, .isoMode, .epIsIn, .pktStart, .pktValid, .pktEnd, .pktCrcOk,
    .inReq, .inRdEn, .inDone, .cpuWrEn, .cpuRdEn, .cpuRelease, .cpuKill,
    .clrFlags, .cntSat, .ctl, .flags, .bankReady, .inReady
  );

  usb_ep_bank_data #(.BANK_BYTES(BANK_BYTES), .DATA_W(DATA_W)) u_data (
    .clk, .rstN, .ctl, .pktData, .cpuWrData, .cnt, .cntSat, .inData, .cpuRdData
  );

  assign cpuByteCount = cnt[ctl.cpuBank];
  assign inLen        = cnt[ctl.pktBank];
  assign irq          = |(flags & intEn);
endmodule

// File: rtl/usb_ep_bank_chk.sv
module usb_ep_bank_chk #(
  parameter int BANK_BYTES = 8,
  localparam int CW = $clog2(BANK_BYTES + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          isoMode,
  input logic          epIsIn,
  input logic          inReq,
  input logic          inReady,
  input logic [3:0]    clrFlags,
  input logic [3:0]    flags,
  input logic          irq,
  input logic [CW-1:0] cpuByteCount,
  input logic [CW-1:0] inLen
);
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flags & $past(flags) & ~$past(clrFlags)) == ($past(flags) & ~$past(clrFlags))));

  p_ovf_with_rx_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[2]) |-> flags[0]);

  p_crc_with_rx_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[3]) |-> flags[0]);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuByteCount <= CW'(BANK_BYTES)) && (inLen <= CW'(BANK_BYTES)));

  p_iso_in_underflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (epIsIn && isoMode && inReq && !inReady) |=> flags[1]);

  p_irq_needs_flag_r12: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flags != 4'b0));
endmodule

bind usb_ep_bank_mgr usb_ep_bank_chk #(.BANK_BYTES(BANK_BYTES)) u_chk (.*);

// File: tb/usb_ep_bank_mgr_tb.sv
module usb_ep_bank_mgr_tb;
  localparam int BB = 4;
  localparam int CW = $clog2(BB + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic isoMode = 0, epIsIn = 0, pktStart = 0, pktValid = 0, pktEnd = 0, pktCrcOk = 1;
  logic [7:0] pktData = '0, cpuWrData = '0;
  logic inReq = 0, inRdEn = 0, inDone = 0, cpuWrEn = 0, cpuRdEn = 0;
  logic cpuRelease = 0, cpuKill = 0;
  logic [3:0] clrFlags = '0, intEn = '0;
  logic [7:0] inData, cpuRdData;
  logic [CW-1:0] inLen, cpuByteCount;
  logic inReady, bankReady, irq;
  logic [3:0] flags;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_ep_bank_mgr #(.BANK_BYTES(BB)) u_dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendOut(int len, int base, bit crcOk);
    pktStart = 1; @(negedge clk); pktStart = 0;
    for (int i = 0; i < len; i++) begin
      pktValid = 1; pktData = 8'(base + i); @(negedge clk);
    end
    pktValid = 0; pktEnd = 1; pktCrcOk = crcOk; @(negedge clk);
    pktEnd = 0; pktCrcOk = 1;
  endtask

  task automatic pulseRd();      cpuRdEn = 1;    @(negedge clk); cpuRdEn = 0;    endtask
  task automatic pulseRel();     cpuRelease = 1; @(negedge clk); cpuRelease = 0; endtask
  task automatic pulseKill();    cpuKill = 1;    @(negedge clk); cpuKill = 0;    endtask
  task automatic pulseReq();     inReq = 1;      @(negedge clk); inReq = 0;      endtask
  task automatic pulseInRd();    inRdEn = 1;     @(negedge clk); inRdEn = 0;     endtask
  task automatic pulseDone();    inDone = 1;     @(negedge clk); inDone = 0;     endtask
  task automatic clrAll();       clrFlags = 4'hF; @(negedge clk); clrFlags = 0;  endtask
  task automatic cpuWrite(int b);
    cpuWrEn = 1; cpuWrData = 8'(b); @(negedge clk); cpuWrEn = 0;
  endtask

  task automatic readOut(string req, int n, int base);
    chk({req, " count"}, cpuByteCount, n);
    for (int i = 0; i < n; i++) begin
      chk({req, " byte"}, cpuRdData, (base + i) & 8'hFF);
      pulseRd();
    end
    pulseRel();
  endtask

  task automatic drainIn(string req, int n, int base);
    chk({req, " inLen"}, inLen, n);
    pulseReq();
    for (int i = 0; i < n; i++) begin
      chk({req, " inData"}, inData, (base + i) & 8'hFF);
      pulseInRd();
    end
    pulseDone();
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 flags", flags, 0);
    chk("R13 bankReady", bankReady, 0);
    chk("R13 inReady", inReady, 0);
    chk("R13 irq", irq, 0);
    rstN = 1; @(negedge clk);

    // R1 / R3: length sweep 0..BB+2, alternating banks
    for (int len = 0; len <= BB + 2; len++) begin
      int kept;
      kept = (len > BB) ? BB : len;
      clrAll();
      sendOut(len, len * 16, 1'b1);
      chk("R1 bankReady", bankReady, 1);
      chk("R1 rx flag", flags[0], 1);
      chk("R3 overflow flag", flags[2], (len > BB) ? 1 : 0);
      readOut("R1/R3", kept, len * 16);
      chk("R2 bank handed back", bankReady, 0);
    end

    // R2 / R5: ping-pong and full-bank drop
    clrAll();
    sendOut(2, 8'h10, 1'b1);
    sendOut(3, 8'h20, 1'b1);
    clrAll();
    sendOut(2, 8'h30, 1'b1);
    chk("R5 non-iso drop no flag", flags, 0);
    isoMode = 1;
    sendOut(1, 8'h40, 1'b1);
    chk("R5 iso drop underflow", flags, 4'b0010);
    isoMode = 0;
    readOut("R2 first bank", 2, 8'h10);
    readOut("R2 second bank", 3, 8'h20);
    chk("R2 empty", bankReady, 0);

    // R7: read with nothing ready
    clrAll();
    pulseRd(); pulseRd();
    chk("R7 no flag", flags, 0);
    sendOut(2, 8'h50, 1'b1);
    readOut("R7 index intact", 2, 8'h50);

    // R4 / R11 / R12
    clrAll();
    sendOut(3, 8'h60, 1'b0);
    chk("R4 crc+rx", flags, 4'b1001);
    repeat (3) @(negedge clk);
    chk("R11 sticky", flags, 4'b1001);
    chk("R12 irq off", irq, 0);
    intEn = 4'b1000; #0;
    chk("R12 irq on", irq, 1);
    clrFlags = 4'b1000; @(negedge clk); clrFlags = 0;
    chk("R11 partial clear", flags, 4'b0001);
    chk("R12 irq follows", irq, 0);
    intEn = 4'b0001; #0;
    chk("R12 irq rx", irq, 1);
    intEn = 0;
    readOut("R4 data kept", 3, 8'h60);

    // R8: IN fill and drain order
    epIsIn = 1; clrAll();
    chk("R8 bankReady", bankReady, 1);
    for (int i = 0; i < 3; i++) cpuWrite(8'hA0 + i);
    pulseRel();
    chk("R8 inReady", inReady, 1);
    for (int i = 0; i < 2; i++) cpuWrite(8'hB0 + i);
    pulseRel();
    chk("R8 both committed", bankReady, 0);
    drainIn("R8 first", 3, 8'hA0);
    chk("R8 still ready", inReady, 1);
    drainIn("R8 second", 2, 8'hB0);
    chk("R8 empty", inReady, 0);

    // R6
    clrAll();
    pulseReq();
    chk("R6 non-iso", flags, 0);
    isoMode = 1; pulseReq(); isoMode = 0;
    chk("R6 iso underflow", flags, 4'b0010);

    // R9: kill
    clrAll();
    cpuWrite(8'hC0); cpuWrite(8'hC1); pulseRel();
    cpuWrite(8'hD0); pulseRel();
    pulseKill();
    chk("R9 bank back", bankReady, 1);
    chk("R9 count zero", cpuByteCount, 0);
    chk("R9 oldest len", inLen, 2);
    pulseReq();
    pulseKill();
    chk("R9 kill while draining ignored", inReady, 1);
    chk("R9 len kept", inLen, 2);
    chk("R9 byte0", inData, 8'hC0);
    pulseInRd();
    chk("R9 byte1", inData, 8'hC1);
    pulseDone();
    chk("R9 killed bank not sent", inReady, 0);
    cpuWrite(8'hE0); pulseRel();
    drainIn("R9 fresh bank", 1, 8'hE0);

    // R10: OUT strobes in IN mode
    clrAll();
    cpuWrite(8'hF0); pulseRel();
    sendOut(0, 0, 1'b0);
    sendOut(3, 8'h77, 1'b1);
    chk("R10 flags", flags, 0);
    chk("R10 inLen", inLen, 1);
    chk("R10 bankReady", bankReady, 1);
    chk("R10 cpu count", cpuByteCount, 0);
    drainIn("R10 data", 1, 8'hF0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule